// File: doc/BRIEF.md
# Boot-Time Pin State Preloader

This block runs once after reset release. It uses an open-drain I2C master to read a small serial-presence-detect style configuration memory. From the record it reads, it sets the port pin output and direction registers before any program image is loaded. Because the record has a fixed size, the time from reset to known pin states is the same for any program. The memory holds 128 bytes. The block reads only the first 18: eight bytes of output levels, eight bytes of pin directions, one boot-source code and one library item number. The later boot stages read the last two from `boot_src` and `lib_idx`.

The memory is optional. If no device acknowledges its address, the block sends a STOP and raises `preload_done` with `cfg_valid` low. The pins then keep their reset values. A memory whose first 16 bytes all read 0xFF counts as blank. A blank memory is treated like a missing one, so nothing is applied. The main program load may start once `preload_done` is high. `preload_done` stays high until the next reset.

The sequencer is a state machine with these states:

| State | Action | Next state |
|---|---|---|
| BEGIN | idles for one cycle after reset | START |
| START | issues START | DEVW |
| DEVW | sends the device address with the write bit | WADDR on ACK, STOP with an abort flag on NACK |
| WADDR | sends word address 0x00 | RESTART on ACK, STOP with an abort flag on NACK |
| RESTART | issues a repeated START | DEVR |
| DEVR | sends the device address with the read bit | READ on ACK, STOP with an abort flag on NACK |
| READ | receives one byte each time it passes through | stays in READ until the 18th byte, then STOP |
| STOP | issues STOP | APPLY |
| APPLY | loads the outputs, or skips them if the abort flag is set or the record is blank | DONE |
| DONE | holds | DONE |

Top module: `bootpin_preload`

## Requirements
- R1: While reset is asserted, every output is low: `port_out`, `port_dir`, `boot_src`, `lib_idx`, `cfg_valid`, `preload_done`, and both line drives, so the bus is released.
- R2: The bus sequence is fixed and in this order:
  - START;
  - `{DEV_ADDR,0}`;
  - word address 0x00;
  - repeated START;
  - `{DEV_ADDR,1}`;
  - 18 data bytes read MSB first, each ACKed by driving SDA low except the last, which gets a NACK;
  - STOP.
- R3: During a data or acknowledge bit, the SDA drive changes only while SCL is driven low. SDA moves with SCL released only inside START and STOP.
- R4: The record layout is fixed:
  - byte k (0..7) sets `port_out[8k+7:8k]`;
  - byte 8+k sets `port_dir[8k+7:8k]`;
  - byte 16 sets `boot_src`;
  - byte 17 sets `lib_idx`.
- R5: `port_out` and `port_dir` stay at zero during the transfer. All their bits change together, only in the cycle in which `preload_done` rises.
- R6: A NACK to the device address ends the transfer with a STOP. The block then raises `preload_done` with `cfg_valid` low and all configuration outputs at zero.
- R7: If bytes 0..15 all read 0xFF, nothing is applied and `cfg_valid` stays low. If any one of these bytes differs from 0xFF, the record is applied and `cfg_valid` goes high.
- R8: Once `preload_done` is high it stays high until reset, with both lines released. For a present memory, the number of cycles from reset release to `preload_done` does not depend on the record contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_drive_low | output | 1 | Pull SCL low (open-drain; released when 0) |
| sda_drive_low | output | 1 | Pull SDA low (open-drain; released when 0) |
| sda_in | input | 1 | Sensed level of the SDA line |
| port_out | output | PORT_W | Preloaded pin output levels |
| port_dir | output | PORT_W | Preloaded pin directions (1 = output) |
| boot_src | output | 8 | Boot-source code from record byte 16 |
| lib_idx | output | 8 | Library item number from record byte 17 |
| cfg_valid | output | 1 | High when a non-blank record was applied |
| preload_done | output | 1 | Preload finished; the main load may begin |

## Verification
The assertions check on every cycle the properties that follow from the relation between the lines and the outputs:
- SDA holds still while SCL is released inside a data bit;
- the pin registers move only on the rising edge of `preload_done`;
- `preload_done` is sticky, and the bus is idle afterwards;
- `cfg_valid` never goes high without `preload_done`.

Only the bench scenarios can show the content-dependent behaviour. These scenarios use a modelled memory:
- the byte order of the record and the exact bus transaction, including the final NACK;
- the absent and blank cases;
- the near-blank boundary, where a single 0xFE byte is applied;
- equal completion times for different records.

// File: rtl/bcp_pkg.sv
package bcp_pkg;

    // Bus primitives executed by the byte engine
    typedef enum logic [1:0] {
        OP_START,
        OP_STOP,
        OP_WRITE,
        OP_READ
    } bus_op_e;

    // Sequencer states
    typedef enum logic [3:0] {
        ST_BEGIN,
        ST_START,
        ST_DEVW,
        ST_WADDR,
        ST_RESTART,
        ST_DEVR,
        ST_READ,
        ST_STOP,
        ST_APPLY,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/bcp_byte_eng.sv
// Executes one bus primitive at a time. Each bit takes four quarter phases
// of QTR_CYC clocks; line drives are registered and held between primitives.
module bcp_byte_eng
    import bcp_pkg::*;
#(
    parameter int QTR_CYC = 4   // must be >= 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_go,
    input  bus_op_e    op_sel,
    input  logic [7:0] wr_byte,
    input  logic       send_ack,
    input  logic       sda_in,
    output logic       op_done,
    output logic [7:0] rd_byte,
    output logic       got_ack,
    output logic       scl_low,
    output logic       sda_low
);
    localparam int TW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(QTR_CYC - 1);

    logic          busy_q;
    bus_op_e       op_q;
    logic [TW-1:0] tick_q;
    logic [1:0]    qtr_q;
    logic [3:0]    bit_q;
    logic [7:0]    tx_q;
    logic          ack_q;
    logic          scl_nx, sda_nx;

    logic       tick_end, is_data;
    logic [3:0] last_bit;
    assign tick_end = (tick_q == TICK_LAST);
    assign is_data  = (op_q == OP_WRITE) || (op_q == OP_READ);
    assign last_bit = is_data ? 4'd8 : 4'd0;

    // Line levels for the current quarter (1 = drive low)
    always_comb begin
        case (op_q)
            OP_START: begin
                scl_nx = (qtr_q == 2'd0) || (qtr_q == 2'd3);
                sda_nx = qtr_q[1];
            end
            OP_STOP: begin
                scl_nx = (qtr_q == 2'd0);
                sda_nx = (qtr_q < 2'd2);
            end
            default: begin
                scl_nx = (qtr_q == 2'd0) || (qtr_q == 2'd3);
                if (bit_q == 4'd8)
                    sda_nx = (op_q == OP_READ) && ack_q;
                else
                    sda_nx = (op_q == OP_WRITE) && !tx_q[7];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            op_q    <= OP_STOP;
            tick_q  <= '0;
            qtr_q   <= 2'd0;
            bit_q   <= 4'd0;
            tx_q    <= 8'h00;
            ack_q   <= 1'b0;
            op_done <= 1'b0;
            rd_byte <= 8'h00;
            got_ack <= 1'b0;
            scl_low <= 1'b0;
            sda_low <= 1'b0;
        end else begin
            op_done <= 1'b0;
            if (!busy_q) begin
                if (op_go) begin
                    busy_q <= 1'b1;
                    op_q   <= op_sel;
                    tx_q   <= wr_byte;
                    ack_q  <= send_ack;
                    tick_q <= '0;
                    qtr_q  <= 2'd0;
                    bit_q  <= 4'd0;
                end
            end else begin
                scl_low <= scl_nx;
                sda_low <= sda_nx;
                if (tick_end) begin
                    tick_q <= '0;
                    qtr_q  <= qtr_q + 2'd1;
                    if (qtr_q == 2'd1 && is_data) begin
                        if (bit_q < 4'd8 && op_q == OP_READ)
                            rd_byte <= {rd_byte[6:0], sda_in};
                        if (bit_q == 4'd8 && op_q == OP_WRITE)
                            got_ack <= !sda_in;
                    end
                    if (qtr_q == 2'd3) begin
                        tx_q <= {tx_q[6:0], 1'b0};
                        if (bit_q == last_bit) begin
                            busy_q  <= 1'b0;
                            op_done <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 4'd1;
                        end
                    end
                end else begin
                    tick_q <= tick_q + TW'(1);
                end
            end
        end
    end

    // R3: data/ack bits never move SDA while SCL is released
    p_sda_stable_scl_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && is_data && $past(busy_q) && !scl_low && !$past(scl_low))
            |-> $stable(sda_low));

    // completion pulse only ends an active primitive
    p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> !busy_q && $past(busy_q));

endmodule

// File: rtl/bcp_rec_buf.sv
// Holds the received record; byte 0 sits at the least significant end.
module bcp_rec_buf #(
    parameter  int PIN_BYTES = 8,
    localparam int REC_BYTES = 2 * PIN_BYTES + 2,
    localparam int IW        = $clog2(REC_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_idx,
    input  logic [7:0]             wr_byte,
    output logic [PIN_BYTES*8-1:0] out_img,
    output logic [PIN_BYTES*8-1:0] dir_img,
    output logic [7:0]             boot_img,
    output logic [7:0]             lib_img,
    output logic                   pins_blank
);
    localparam int PW = PIN_BYTES * 8;

    logic [REC_BYTES*8-1:0] rec_flat;

    for (genvar g = 0; g < REC_BYTES; g++) begin : g_byte
        logic [7:0] b_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                b_q <= 8'h00;
            else if (wr_en && wr_idx == IW'(g))
                b_q <= wr_byte;
        end
        assign rec_flat[g*8 +: 8] = b_q;
    end

    assign out_img    = rec_flat[PW-1:0];
    assign dir_img    = rec_flat[2*PW-1:PW];
    assign boot_img   = rec_flat[2*PW +: 8];
    assign lib_img    = rec_flat[2*PW+8 +: 8];
    assign pins_blank = &rec_flat[2*PW-1:0];

endmodule

// File: rtl/bootpin_preload.sv
module bootpin_preload
    import bcp_pkg::*;
#(
    parameter int         PORT_W   = 64,
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         QTR_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic              sda_in,
    output logic [PORT_W-1:0] port_out,
    output logic [PORT_W-1:0] port_dir,
    output logic [7:0]        boot_src,
    output logic [7:0]        lib_idx,
    output logic              cfg_valid,
    output logic              preload_done
);
    localparam int PIN_BYTES = PORT_W / 8;
    localparam int REC_BYTES = 2 * PIN_BYTES + 2;
    localparam int IW        = $clog2(REC_BYTES);
    localparam logic [IW-1:0] LAST_IDX = IW'(REC_BYTES - 1);

    seq_state_e state_q, state_d;
    logic          wait_q, abort_q;
    logic [IW-1:0] byte_cnt;

    logic       op_go, send_ack, in_op;
    bus_op_e    op_sel;
    logic [7:0] wr_byte;
    logic       op_done, got_ack;
    logic [7:0] rd_byte;

    logic [PORT_W-1:0] out_img, dir_img;
    logic [7:0]        boot_img, lib_img;
    logic              img_blank;

    bcp_byte_eng #(.QTR_CYC(QTR_CYC)) eng_i (
        .clk(clk), .rst_n(rst_n), .op_go(op_go), .op_sel(op_sel),
        .wr_byte(wr_byte), .send_ack(send_ack), .sda_in(sda_in),
        .op_done(op_done), .rd_byte(rd_byte), .got_ack(got_ack),
        .scl_low(scl_drive_low), .sda_low(sda_drive_low)
    );

    bcp_rec_buf #(.PIN_BYTES(PIN_BYTES)) buf_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(state_q == ST_READ && op_done), .wr_idx(byte_cnt), .wr_byte(rd_byte),
        .out_img(out_img), .dir_img(dir_img), .boot_img(boot_img),
        .lib_img(lib_img), .pins_blank(img_blank)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BEGIN;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BEGIN:   state_d = ST_START;
            ST_START:   if (op_done) state_d = ST_DEVW;
            ST_DEVW:    if (op_done) state_d = got_ack ? ST_WADDR : ST_STOP;
            ST_WADDR:   if (op_done) state_d = got_ack ? ST_RESTART : ST_STOP;
            ST_RESTART: if (op_done) state_d = ST_DEVR;
            ST_DEVR:    if (op_done) state_d = got_ack ? ST_READ : ST_STOP;
            ST_READ:    if (op_done && byte_cnt == LAST_IDX) state_d = ST_STOP;
            ST_STOP:    if (op_done) state_d = ST_APPLY;
            ST_APPLY:   state_d = ST_DONE;
            ST_DONE:    state_d = ST_DONE;
            default:    state_d = ST_BEGIN;
        endcase
    end

    // Engine command outputs
    always_comb begin
        in_op    = 1'b1;
        op_sel   = OP_START;
        wr_byte  = 8'h00;
        send_ack = 1'b0;
        unique case (state_q)
            ST_START, ST_RESTART: op_sel = OP_START;
            ST_DEVW: begin
                op_sel  = OP_WRITE;
                wr_byte = {DEV_ADDR, 1'b0};
            end
            ST_WADDR: op_sel = OP_WRITE;
            ST_DEVR: begin
                op_sel  = OP_WRITE;
                wr_byte = {DEV_ADDR, 1'b1};
            end
            ST_READ: begin
                op_sel   = OP_READ;
                send_ack = (byte_cnt != LAST_IDX);
            end
            ST_STOP: op_sel = OP_STOP;
            default: in_op = 1'b0;
        endcase
        op_go = in_op && !wait_q;
    end

    // Sequencer datapath and block outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q       <= 1'b0;
            abort_q      <= 1'b0;
            byte_cnt     <= '0;
            port_out     <= '0;
            port_dir     <= '0;
            boot_src     <= 8'h00;
            lib_idx      <= 8'h00;
            cfg_valid    <= 1'b0;
            preload_done <= 1'b0;
        end else begin
            if (op_go)   wait_q <= 1'b1;
            if (op_done) wait_q <= 1'b0;
            if (op_done && !got_ack &&
                (state_q == ST_DEVW || state_q == ST_WADDR || state_q == ST_DEVR))
                abort_q <= 1'b1;
            if (state_q == ST_READ && op_done)
                byte_cnt <= byte_cnt + IW'(1);
            if (state_q == ST_APPLY) begin
                preload_done <= 1'b1;
                if (!abort_q && !img_blank) begin
                    port_out  <= out_img;
                    port_dir  <= dir_img;
                    boot_src  <= boot_img;
                    lib_idx   <= lib_img;
                    cfg_valid <= 1'b1;
                end
            end
        end
    end

    // R5: pin registers move only together with the rise of preload_done
    p_pins_move_at_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(port_out) || !$stable(port_dir)) |-> $rose(preload_done));

    // R8: done is sticky and the bus is left released
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        preload_done |=> preload_done);
    p_bus_idle_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        preload_done |-> !scl_drive_low && !sda_drive_low);

    // R6: validity never precedes completion
    p_valid_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> preload_done);

    // R7: a blank record in the buffer is never marked valid
    p_blank_not_applied_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY && img_blank) |=> !cfg_valid);

endmodule

// File: tb/bootpin_preload_tb_top.sv
module bootpin_preload_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] ADDR = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        scl_drive_low, sda_drive_low;
    logic [63:0] port_out, port_dir;
    logic [7:0]  boot_src, lib_idx;
    logic        cfg_valid, preload_done;

    logic slv_low = 1'b0;
    wire  scl_line = !scl_drive_low;
    wire  sda_line = !(sda_drive_low || slv_low);

    bootpin_preload #(.PORT_W(64), .DEV_ADDR(ADDR), .QTR_CYC(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .sda_in(sda_line),
        .port_out(port_out), .port_dir(port_dir),
        .boot_src(boot_src), .lib_idx(lib_idx),
        .cfg_valid(cfg_valid), .preload_done(preload_done)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem [128];
    bit         present;
    bit         s_active, s_tx, s_rw, s_mack;
    int         s_bit, s_byte_no;
    logic [7:0] s_sh;
    logic [6:0] s_ptr;
    logic       scl_p, sda_p;
    int         n_stop, n_tx, saw_w, saw_r;
    logic [7:0] waddr_rx;
    bit         last_mack;

    always @(negedge clk) begin
        if (!rst_n) begin
            s_active = 0; s_tx = 0; slv_low = 0; s_bit = 0; s_byte_no = 0;
            scl_p = 1; sda_p = 1; n_stop = 0; n_tx = 0; saw_w = 0; saw_r = 0;
            waddr_rx = 8'hAA; last_mack = 1;
        end else begin
            if (scl_line && scl_p && sda_p && !sda_line) begin
                s_active = 1; s_tx = 0; s_bit = 0; s_byte_no = 0; slv_low = 0;
            end else if (scl_line && scl_p && !sda_p && sda_line) begin
                s_active = 0; slv_low = 0; n_stop++;
            end else if (s_active && scl_line && !scl_p) begin
                s_bit++;
                if (!s_tx && s_bit <= 8) s_sh = {s_sh[6:0], sda_line};
                if (s_tx && s_bit == 9) s_mack = !sda_line;
            end else if (s_active && !scl_line && scl_p) begin
                if (!s_tx) begin
                    if (s_bit == 8) begin
                        if (s_byte_no == 0) begin
                            if (present && s_sh[7:1] == ADDR) begin
                                s_rw = s_sh[0]; slv_low = 1;
                                if (s_rw) saw_r++; else saw_w++;
                            end else begin
                                s_active = 0;
                            end
                        end else begin
                            s_ptr = s_sh[6:0]; waddr_rx = s_sh; slv_low = 1;
                        end
                    end else if (s_bit == 9) begin
                        slv_low = 0; s_bit = 0;
                        if (s_byte_no == 0 && s_rw) begin
                            s_tx = 1; s_sh = mem[s_ptr]; s_ptr++; slv_low = !s_sh[7]; n_tx++;
                        end
                        s_byte_no++;
                    end
                end else begin
                    if (s_bit >= 1 && s_bit <= 7) slv_low = !s_sh[7 - s_bit];
                    else if (s_bit == 8) slv_low = 0;
                    else if (s_bit == 9) begin
                        last_mack = s_mack;
                        if (s_mack) begin
                            s_sh = mem[s_ptr]; s_ptr++; slv_low = !s_sh[7]; n_tx++; s_bit = 0;
                        end else begin
                            slv_low = 0; s_active = 0;
                        end
                    end
                end
            end
            scl_p = scl_line; sda_p = sda_line;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [63:0] o;
        logic [63:0] d;
        logic [7:0]  b;
        logic [7:0]  l;
        logic        v;
    } exp_t;
    exp_t sb_q[$];
    int   n_popped = 0;

    // R4 layout: byte k -> out[8k+:8], byte 8+k -> dir[8k+:8], 16 boot, 17 lib
    function automatic exp_t expect_from_mem(input bit apply);
        exp_t e;
        e = '{o: 64'h0, d: 64'h0, b: 8'h0, l: 8'h0, v: 1'b0};
        if (apply) begin
            for (int k = 0; k < 8; k++) begin
                e.o[8*k +: 8] = mem[k];
                e.d[8*k +: 8] = mem[8+k];
            end
            e.b = mem[16];
            e.l = mem[17];
            e.v = 1'b1;
        end
        return e;
    endfunction

    initial begin
        forever begin
            @(posedge preload_done);
            @(negedge clk);
            if (sb_q.size() == 0) begin
                check(0, "R5", "unexpected done", 0, 1);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(port_out === e.o, "R4", "port_out", port_out, e.o);
                check(port_dir === e.d, "R4", "port_dir", port_dir, e.d);
                check(boot_src === e.b, "R4", "boot_src", 64'(boot_src), 64'(e.b));
                check(lib_idx  === e.l, "R4", "lib_idx", 64'(lib_idx), 64'(e.l));
                check(cfg_valid === e.v, "R6/R7", "cfg_valid", 64'(cfg_valid), 64'(e.v));
            end
            n_popped++;
        end
    end

    int last_cycles;

    task automatic run_case(input string tag, input bit pres, input bit apply);
        int cyc;
        int want;
        present = pres;
        sb_q.push_back(expect_from_mem(apply));
        want = n_popped + 1;
        @(negedge clk); rst_n = 0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check({port_out, port_dir, boot_src, lib_idx, cfg_valid, preload_done,
               scl_drive_low, sda_drive_low} == '0, "R1", {tag, " reset state"},
              port_out | port_dir, 0);
        rst_n = 1;
        cyc = 0;
        while (!preload_done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1500)
                check(port_out == 0 && port_dir == 0 && !preload_done, "R5",
                      {tag, " pins held mid-transfer"}, port_out | port_dir, 0);
        end
        last_cycles = cyc;
        while (n_popped < want) @(negedge clk);
        repeat (60) @(negedge clk);
        check(preload_done && !scl_drive_low && !sda_drive_low, "R8",
              {tag, " done sticky, bus idle"}, 64'(preload_done), 1);
        if (pres) begin
            check(n_tx == 18 && last_mack == 0 && waddr_rx == 8'h00 && saw_w == 1 && saw_r == 1,
                  "R2", {tag, " bus transaction"}, 64'(n_tx), 18);
        end else begin
            check(n_tx == 0 && saw_w == 0, "R6", {tag, " no data read"}, 64'(n_tx), 0);
        end
        check(n_stop == 1, pres ? "R2" : "R6", {tag, " one STOP"}, 64'(n_stop), 1);
    endtask

    initial begin
        int cyc_a;
        for (int i = 0; i < 128; i++) mem[i] = 8'(i * 37 + 5);
        mem[16] = 8'h02; mem[17] = 8'h07;
        run_case("patternA", 1, 1);
        cyc_a = last_cycles;

        // dir all ones, out all zero
        for (int i = 0; i < 8; i++) begin mem[i] = 8'h00; mem[8+i] = 8'hFF; end
        mem[16] = 8'hC3; mem[17] = 8'h81;
        run_case("patternB", 1, 1);
        check(last_cycles == cyc_a, "R8", "fixed completion time", 64'(last_cycles), 64'(cyc_a));

        run_case("absent", 0, 0);

        for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
        mem[16] = 8'h03; mem[17] = 8'h09;
        run_case("blank", 1, 0);

        mem[15] = 8'hFE;
        run_case("near_blank", 1, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule